// File: doc/BRIEF.md
# Tie-Programmed Branching Sequencer

This block is a small control sequencer built around a loadable binary state counter. In each state, two per-state selectors decide what happens at the next clock edge. The load selector decides whether the counter loads a branch target. The count selector decides whether the counter advances or holds. Each selector input is fed with one 2-bit code per state. A code ties that state's input low or high, or to one of two external condition lines. The program is therefore set entirely by these configuration vectors, and no next-state logic has to be minimized.

The current state drives a decoder that raises exactly one unary strobe, whether or not the state is used. These strobes are the block's useful outputs. A priority encoder over a vector of branch requests supplies the branch target: the highest-numbered asserted request sets the target index. When no request is asserted, a configured default target is used. Setting that default to 1 lets state 0 serve as a run-once initialization step.

All pins are plain level signals sampled every clock. There is no streaming data interface, so no valid/ready handshake or back-pressure applies.

Top module: `cond_sequencer`

## Requirements
- R1: A synchronous active-high `rst` forces `state` to 0 at the next rising clock edge.
- R2: In a state whose load code is 00 and whose count code is 01, the next state is `state`+1, and the counter wraps from 15 to 0.
- R3: `strobe` always has exactly one bit set, and that bit is at index `state`.
- R4: In a state whose load code is 01, the next state is the branch target.
- R5: Load code 10 branches only when `cond_a` is 1, and load code 11 branches only when `cond_b` is 1. Otherwise the count code decides the next state.
- R6: In a state with load code 00 and count code 00, the state holds.
- R7: Count code 10 advances only when `cond_a` is 1, and count code 11 advances only when `cond_b` is 1. Otherwise the state holds.
- R8: When load and count are both active, the load wins, including in a state whose count code is 00.
- R9: The branch target is the index of the highest-numbered set bit of `branch_req`. When no bit is set, the target is `default_target`.
- R10: With `default_target` = 1 and a load code of 01 in the last state, the sequence runs 0,1,…,15,1,2,… and state 0 never returns after reset.
- R11: State s takes its load code from `load_tie[2s+1:2s]` and its count code from `count_tie[2s+1:2s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_a | input | 1 | External condition line A |
| cond_b | input | 1 | External condition line B |
| load_tie | input | 2*NUM_STATES (32) | Per-state load codes: 00 low, 01 high, 10 A, 11 B |
| count_tie | input | 2*NUM_STATES (32) | Per-state count codes: same encoding |
| default_target | input | STATE_W (4) | Target used when no request is set |
| branch_req | input | NUM_STATES (16) | Branch requests; bit i requests target i |
| state | output | STATE_W (4) | Current state |
| strobe | output | NUM_STATES (16) | One-hot decode of `state` |

## Verification
The counter is first run free with every code at its neutral value. This shows increment and wrap apart from any branching. Each load code and count code is then placed in a single state and tried with its condition line both high and low. This tells a branch apart from a fall-through, and a wait apart from an advance. Request patterns with zero, one and two bits set separate the default-target path from the highest-index pick. A load set in a state that is also halted shows which enable has priority. A looping run with default target 1 confirms that state 0 is run only once.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    TIE_LOW  = 2'b00,
    TIE_HIGH = 2'b01,
    TIE_CA   = 2'b10,
    TIE_CB   = 2'b11
  } tie_code_e;

  localparam int TIE_W = 2;
endpackage

// File: rtl/tie_select.sv
module tie_select
  import cseq_pkg::*;
#(
  parameter int STATE_W = 4,
  localparam int NUM_STATES = 1 << STATE_W
) (
  input  logic [TIE_W*NUM_STATES-1:0] ties,
  input  logic [STATE_W-1:0]          sel,
  input  logic                        cond_a,
  input  logic                        cond_b,
  output logic                        en
);
  tie_code_e code;

  always_comb begin
    code = tie_code_e'(ties[TIE_W*int'(sel) +: TIE_W]);
    unique case (code)
      TIE_LOW:  en = 1'b0;
      TIE_HIGH: en = 1'b1;
      TIE_CA:   en = cond_a;
      TIE_CB:   en = cond_b;
      default:  en = 1'b0;
    endcase
  end
endmodule

// File: rtl/state_counter.sv
module state_counter #(
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               count,
  input  logic [STATE_W-1:0] preset,
  output logic [STATE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= preset;
    else if (count) q <= q + 1'b1;
  end
endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
  parameter int STATE_W = 4,
  localparam int NUM_STATES = 1 << STATE_W
) (
  input  logic [STATE_W-1:0]    code,
  output logic [NUM_STATES-1:0] lines
);
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_line
    assign lines[i] = (code == STATE_W'(i));
  end
endmodule

// File: rtl/target_encoder.sv
module target_encoder #(
  parameter int STATE_W = 4,
  localparam int NUM_STATES = 1 << STATE_W
) (
  input  logic [NUM_STATES-1:0] req,
  input  logic [STATE_W-1:0]    dflt,
  output logic [STATE_W-1:0]    target
);
  always_comb begin
    target = dflt;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (req[i]) target = STATE_W'(i);
    end
  end
endmodule

// File: rtl/cond_sequencer.sv
module cond_sequencer
  import cseq_pkg::*;
#(
  parameter int STATE_W = 4,
  localparam int NUM_STATES = 1 << STATE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cond_a,
  input  logic                        cond_b,
  input  logic [TIE_W*NUM_STATES-1:0] load_tie,
  input  logic [TIE_W*NUM_STATES-1:0] count_tie,
  input  logic [STATE_W-1:0]          default_target,
  input  logic [NUM_STATES-1:0]       branch_req,
  output logic [STATE_W-1:0]          state,
  output logic [NUM_STATES-1:0]       strobe
);
  logic               load_en;
  logic               count_en;
  logic [STATE_W-1:0] target;

  tie_select #(.STATE_W(STATE_W)) u_load_sel (
    .ties(load_tie), .sel(state), .cond_a(cond_a), .cond_b(cond_b), .en(load_en)
  );

  tie_select #(.STATE_W(STATE_W)) u_count_sel (
    .ties(count_tie), .sel(state), .cond_a(cond_a), .cond_b(cond_b), .en(count_en)
  );

  target_encoder #(.STATE_W(STATE_W)) u_target (
    .req(branch_req), .dflt(default_target), .target(target)
  );

  state_counter #(.STATE_W(STATE_W)) u_counter (
    .clk(clk), .rst(rst), .load(load_en), .count(count_en),
    .preset(target), .q(state)
  );

  onehot_decoder #(.STATE_W(STATE_W)) u_decode (
    .code(state), .lines(strobe)
  );
endmodule

// File: rtl/cseq_chk.sv
module cseq_chk
  import cseq_pkg::*;
#(
  parameter int STATE_W = 4,
  localparam int NUM_STATES = 1 << STATE_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic [TIE_W*NUM_STATES-1:0] load_tie,
  input logic [TIE_W*NUM_STATES-1:0] count_tie,
  input logic [STATE_W-1:0]          default_target,
  input logic [NUM_STATES-1:0]       branch_req,
  input logic [STATE_W-1:0]          state,
  input logic [NUM_STATES-1:0]       strobe
);
  logic [1:0] lcode, ccode;
  assign lcode = load_tie[TIE_W*int'(state) +: TIE_W];
  assign ccode = count_tie[TIE_W*int'(state) +: TIE_W];

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> state == '0);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe) == 1 && strobe[state]);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (lcode == 2'b00 && ccode == 2'b01) |=> state == $past(state) + 1'b1);

  // R6
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (lcode == 2'b00 && ccode == 2'b00) |=> $stable(state));

  // R9
  default_target_chk: assert property (@(posedge clk) disable iff (rst)
    (lcode == 2'b01 && branch_req == '0) |=> state == $past(default_target));
endmodule

bind cond_sequencer cseq_chk #(.STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .load_tie(load_tie), .count_tie(count_tie),
  .default_target(default_target), .branch_req(branch_req),
  .state(state), .strobe(strobe)
);

// File: tb/tb_cond_sequencer.sv
module tb_cond_sequencer;
  localparam int SW = 4;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          cond_a = 1'b0, cond_b = 1'b0;
  logic [2*NS-1:0] load_tie, count_tie;
  logic [SW-1:0] default_target = '0;
  logic [NS-1:0] branch_req = '0;
  logic [SW-1:0] state;
  logic [NS-1:0] strobe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_sequencer dut (
    .clk(clk), .rst(rst), .cond_a(cond_a), .cond_b(cond_b),
    .load_tie(load_tie), .count_tie(count_tie),
    .default_target(default_target), .branch_req(branch_req),
    .state(state), .strobe(strobe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic neutral();
    load_tie = '0;
    count_tie = {NS{2'b01}};
    cond_a = 0; cond_b = 0; branch_req = '0; default_target = '0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); rst = 0;
  endtask

  task automatic run_to(int s);
    do_reset();
    for (int i = 0; i < s; i++) tick();
  endtask

  task automatic t_reset();
    neutral(); run_to(5);
    do_reset();
    chk("R1", state, 0);
    chk("R3", strobe, 1);
  endtask

  task automatic t_count();
    neutral(); do_reset();
    for (int k = 1; k <= 17; k++) begin
      tick();
      chk("R2", state, k % NS);
      chk("R3", strobe, 1 << (k % NS));
    end
  endtask

  task automatic t_uncond();
    neutral(); default_target = 9;
    load_tie[2*3 +: 2] = 2'b01;
    run_to(3); tick();
    chk("R4", state, 9);
    chk("R11", strobe, 1 << 9);
  endtask

  task automatic t_cond();
    neutral(); default_target = 11;
    load_tie[2*2 +: 2] = 2'b10;
    load_tie[2*7 +: 2] = 2'b11;
    run_to(3);
    chk("R5", state, 3);
    cond_a = 1; run_to(3);
    chk("R5", state, 11);
    cond_a = 0; run_to(8);
    chk("R5", state, 8);
    cond_b = 1; run_to(8);
    chk("R5", state, 11);
  endtask

  task automatic t_halt();
    neutral();
    count_tie[2*5 +: 2] = 2'b00;
    run_to(5);
    for (int i = 0; i < 3; i++) tick();
    chk("R6", state, 5);
  endtask

  task automatic t_wait();
    neutral();
    count_tie[2*4 +: 2] = 2'b11;
    count_tie[2*9 +: 2] = 2'b10;
    run_to(4);
    for (int i = 0; i < 3; i++) tick();
    chk("R7", state, 4);
    cond_a = 1; tick();
    chk("R7", state, 4);
    cond_b = 1; tick();
    chk("R7", state, 5);
    cond_a = 0; run_to(9); tick(); tick();
    chk("R7", state, 9);
    cond_a = 1; tick();
    chk("R7", state, 10);
  endtask

  task automatic t_prio();
    neutral(); default_target = 2;
    load_tie[2*6 +: 2] = 2'b01;
    count_tie[2*6 +: 2] = 2'b00;
    run_to(6);
    branch_req = 16'h1008; tick();
    chk("R8", state, 12);
    branch_req = 16'h0008; run_to(7);
    chk("R9", state, 3);
    branch_req = '0; run_to(7);
    chk("R9", state, 2);
  endtask

  task automatic t_init();
    int zeros = 0;
    neutral(); default_target = 1;
    load_tie[2*15 +: 2] = 2'b01;
    do_reset();
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (state == 0) zeros++;
      chk("R10", state, ((k - 1) % 15) + 1);
    end
    chk("R10", zeros, 0);
  endtask

  initial begin
    neutral();
    t_reset();
    t_count();
    t_uncond();
    t_cond();
    t_halt();
    t_wait();
    t_prio();
    t_init();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule